// File: doc/BRIEF.md
# MII link and duplex resolver

This block decides whether one Ethernet PHY is present and has link, and it keeps the MAC operating-mode word in step with the speed and duplex the PHY has negotiated. A one-cycle `start` pulse begins a check. The block then reads the PHY's basic status register and its link-partner ability register through a simple request/response port. The port faces an MDIO master, which handles the serial framing.

The status link bit latches low. When a first read shows it clear, the block reads status a second time before it reports the link as down. A status value of all ones means no PHY answered. Otherwise the partner ability is masked by the local advertisement. That masked value sets or clears the transmit-threshold bit and the full-duplex bit of the mode word. When the word differs from the stored copy, the block saves it and pulses `restart` so that the MAC can be restarted.

Each check ends with a `done` pulse and a 2-bit result code: 0 for unchanged, 1 for changed, 2 for no link and 3 for transceiver missing.

Top module: `mii_link_resolver`

## Requirements
- R1: A check issues one register read at a time, all to the PHY address given with `start`. The first read is register 1 (status) and the second is register 5 (partner ability).
- R2: A first status value of 0xFFFF ends the check after the partner read. The result is code 3, the mode word is unchanged, `restart` stays low and no third read is made.
- R3: If status bit 2 is clear, a third read of register 1 is made. If bit 2 is also clear in that read, the result is code 2 and the mode word is unchanged. If it is set, the check goes on to evaluation.
- R4: The negotiated set is the partner ability ANDed with the advertisement value given with `start`.
- R5: Mode bit TXTH_BIT (default 22) is cleared when any of bits 9..7 of the negotiated set is 1, and set otherwise.
- R6: Mode bit FD_BIT (default 9) is 1 when the duplex lock is high. Otherwise it is 1 exactly when negotiated bit 8 is set, or when bit 6 is set and bits 8 and 7 are both clear.
- R7: If the new mode word differs from the stored one, it is stored, result code 1 is given and `restart` pulses for one cycle together with `done`. Otherwise the result is code 0 with no restart. All other mode bits keep their value.
- R8: `done` is a one-cycle pulse that carries the result. A `start` that arrives while a check is running is ignored.
- R9: After reset the mode word equals MODE_RESET (default 0x020E0000), and `done`, `restart` and `mdio_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (ignored when busy) |
| phy_addr | input | PHY_W | PHY address for this check |
| adv | input | 16 | Local advertisement value |
| duplex_lock | input | 1 | Force full duplex |
| mdio_req | output | 1 | Read request, held until answered |
| mdio_phy | output | PHY_W | PHY address of the request |
| mdio_reg | output | REG_W | Register address of the request |
| mdio_rsp_valid | input | 1 | Read data valid, seen only while `mdio_req` is high |
| mdio_rsp_data | input | 16 | Read data |
| done | output | 1 | Check finished |
| result | output | 2 | 0 unchanged, 1 changed, 2 no link, 3 missing |
| restart | output | 1 | Mode word changed, restart the MAC |
| mode_word | output | MODE_W | MAC operating-mode word |

## Verification
The assertions check several rules on every cycle:
- The mode word only moves in a cycle that reports code 1.
- `restart` never appears without a "changed" result.
- `done` is always a single-cycle pulse.
- Requests only ever address the status or partner registers.

Only the bench scenarios can show the rest: the read order and count per path, the re-read of a latched-low link bit, the masking of partner ability by the advertisement, the exact threshold and duplex values for each ability pattern, and that a `start` during a running check starts nothing.

// File: rtl/mii_link_resolver.sv
module mii_link_resolver #(
  parameter int                PHY_W      = 5,
  parameter int                REG_W      = 5,
  parameter int                MODE_W     = 32,
  parameter int                TXTH_BIT   = 22,
  parameter int                FD_BIT     = 9,
  parameter logic [MODE_W-1:0] MODE_RESET = 32'h020E0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [15:0]       adv,
  input  logic              duplex_lock,
  output logic              mdio_req,
  output logic [PHY_W-1:0]  mdio_phy,
  output logic [REG_W-1:0]  mdio_reg,
  input  logic              mdio_rsp_valid,
  input  logic [15:0]       mdio_rsp_data,
  output logic              done,
  output logic [1:0]        result,
  output logic              restart,
  output logic [MODE_W-1:0] mode_word
);
  localparam logic [REG_W-1:0] REG_STAT  = REG_W'(1);
  localparam logic [REG_W-1:0] REG_PART  = REG_W'(5);
  localparam int               LINK_BIT  = 2;
  localparam logic [15:0]      FAST_MASK = 16'h0380;
  localparam logic [1:0] RES_SAME = 2'd0, RES_CHG = 2'd1, RES_NOLINK = 2'd2, RES_MISS = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_PART, S_STAT2, S_EVAL} state_t;

  state_t             state;
  logic [PHY_W-1:0]   phy_q;
  logic [15:0]        adv_q, stat_q, part_q;
  logic               lock_q;
  logic [MODE_W-1:0]  mode_q, mode_next;
  logic [15:0]        neg;
  logic               fast, full;

  assign mdio_req  = (state == S_STAT) || (state == S_PART) || (state == S_STAT2);
  assign mdio_reg  = (state == S_PART) ? REG_PART : REG_STAT;
  assign mdio_phy  = phy_q;
  assign mode_word = mode_q;

  assign neg  = part_q & adv_q;
  assign fast = |(neg & FAST_MASK);
  assign full = lock_q | neg[8] | (neg[6] & ~neg[7] & ~neg[8]);

  always_comb begin
    mode_next           = mode_q;
    mode_next[TXTH_BIT] = ~fast;
    mode_next[FD_BIT]   = full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phy_q   <= '0;
      adv_q   <= '0;
      lock_q  <= 1'b0;
      stat_q  <= '0;
      part_q  <= '0;
      mode_q  <= MODE_RESET;
      done    <= 1'b0;
      result  <= RES_SAME;
      restart <= 1'b0;
    end else begin
      done    <= 1'b0;
      restart <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          phy_q  <= phy_addr;
          adv_q  <= adv;
          lock_q <= duplex_lock;
          state  <= S_STAT;
        end
        S_STAT: if (mdio_rsp_valid) begin
          stat_q <= mdio_rsp_data;
          state  <= S_PART;
        end
        S_PART: if (mdio_rsp_valid) begin
          part_q <= mdio_rsp_data;
          if (stat_q == 16'hFFFF) begin
            done   <= 1'b1;
            result <= RES_MISS;
            state  <= S_IDLE;
          end else if (!stat_q[LINK_BIT]) begin
            state <= S_STAT2;
          end else begin
            state <= S_EVAL;
          end
        end
        S_STAT2: if (mdio_rsp_valid) begin
          if (!mdio_rsp_data[LINK_BIT]) begin
            done   <= 1'b1;
            result <= RES_NOLINK;
            state  <= S_IDLE;
          end else begin
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          done  <= 1'b1;
          state <= S_IDLE;
          if (mode_next != mode_q) begin
            mode_q  <= mode_next;
            restart <= 1'b1;
            result  <= RES_CHG;
          end else begin
            result <= RES_SAME;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_link_resolver_chk.sv
module mii_link_resolver_chk #(
  parameter int MODE_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_req,
  input logic [REG_W-1:0]  mdio_reg,
  input logic              done,
  input logic [1:0]        result,
  input logic              restart,
  input logic [MODE_W-1:0] mode_word
);
  a_r1_reg_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_reg == REG_W'(1)) || (mdio_reg == REG_W'(5)));

  a_r7_restart_changed: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> done && (result == 2'd1));

  a_r7_mode_moves_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_word != $past(mode_word)) |-> done && (result == 2'd1));

  a_r2_no_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result != 2'd1)) |-> $stable(mode_word) && !restart);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_req);
endmodule

bind mii_link_resolver mii_link_resolver_chk #(.MODE_W(MODE_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_reg(mdio_reg),
  .done(done), .result(result), .restart(restart), .mode_word(mode_word));

// File: tb/tb_mii_link_resolver.sv
module tb_mii_link_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [15:0] adv_in = '0;
  logic        dlock = 1'b0;
  logic        mdio_req;
  logic [4:0]  mdio_phy, mdio_reg;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        done, restart;
  logic [1:0]  result;
  logic [31:0] mode_word;

  int checks = 0, errors = 0;
  logic [31:0] model_mode = 32'h020E0000;

  always #10 clk = ~clk;

  mii_link_resolver dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr), .adv(adv_in),
    .duplex_lock(dlock), .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_rsp_valid(rsp_valid), .mdio_rsp_data(rsp_data), .done(done),
    .result(result), .restart(restart), .mode_word(mode_word));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_chk(input string tag, input logic [4:0] phy, input logic [15:0] st1,
                         input logic [15:0] st2, input logic [15:0] part, input logic [15:0] adv,
                         input bit lock, input bit poke);
    int nreads = 0, st_reads = 0, wait_c = 0, cyc = 0;
    bit got = 0, seq_ok = 1, extra = 0;
    logic [1:0] e_res, a_res = '0;
    logic a_rs = 0;
    logic [31:0] a_mw = '0, nm;
    logic [15:0] neg;
    int e_reads;
    // independent expectation from the requirements
    neg = part & adv;
    nm = model_mode;
    nm[22] = ((neg & 16'h0380) == 16'h0);
    nm[9]  = lock || neg[8] || (neg[6] && !neg[7] && !neg[8]);
    if (st1 == 16'hFFFF) begin e_res = 2'd3; e_reads = 2; end
    else if (!st1[2] && !st2[2]) begin e_res = 2'd2; e_reads = 3; end
    else begin
      e_reads = st1[2] ? 2 : 3;
      e_res = (nm != model_mode) ? 2'd1 : 2'd0;
    end
    @(negedge clk);
    phy_addr = phy; adv_in = adv; dlock = lock; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!got && cyc < 2000) begin
      if (done) begin
        got = 1; a_res = result; a_rs = restart; a_mw = mode_word;
      end else if (rsp_valid) begin
        rsp_valid = 1'b0;
      end else if (mdio_req) begin
        if (wait_c == 2) begin
          wait_c = 0;
          if (mdio_phy != phy) seq_ok = 0;
          if (nreads == 1) begin
            if (mdio_reg != 5'd5) seq_ok = 0;
            rsp_data = part;
          end else begin
            if (mdio_reg != 5'd1) seq_ok = 0;
            rsp_data = (st_reads == 0) ? st1 : st2;
            st_reads++;
          end
          rsp_valid = 1'b1;
          nreads++;
          if (poke && nreads == 1) start = 1'b1;
        end else wait_c++;
      end
      if (!got) begin
        @(negedge clk);
        start = 1'b0;
        cyc++;
      end
    end
    rsp_valid = 1'b0;
    if (poke) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (mdio_req || done) extra = 1;
      end
      chk(!extra, {tag, " R8 start while busy ignored"}, 32'(extra), 32'd0);
    end
    chk(got, {tag, " R8 done seen"}, 32'(got), 32'd1);
    chk(a_res == e_res, {tag, " R7 result code"}, 32'(a_res), 32'(e_res));
    chk(seq_ok, {tag, " R1 read order and address"}, 32'(seq_ok), 32'd1);
    chk(nreads == e_reads, {tag, " R3 read count"}, 32'(nreads), 32'(e_reads));
    if (e_res == 2'd1) model_mode = nm;
    chk(a_mw == model_mode, {tag, " R5 R6 mode word"}, a_mw, model_mode);
    chk(a_rs == (e_res == 2'd1), {tag, " R7 restart pulse"}, 32'(a_rs), 32'(e_res == 2'd1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode_word == 32'h020E0000, "R9 reset mode word", mode_word, 32'h020E0000);
    chk(!done && !restart && !mdio_req, "R9 reset outputs low",
        {29'd0, done, restart, mdio_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 absent transceiver
    run_chk("missing R2",  5'd3,  16'hFFFF, 16'hFFFF, 16'h45E1, 16'h01E1, 0, 0);
    // R3 link down on both status reads
    run_chk("nolink R3",   5'd7,  16'h7809, 16'h7809, 16'h45E1, 16'h01E1, 0, 0);
    // R3 latched-low link recovers on the re-read; 100 full
    run_chk("latched R3",  5'd1,  16'h7809, 16'h782D, 16'h45E1, 16'h01E1, 0, 0);
    // R7 identical outcome again
    run_chk("same R7",     5'd1,  16'h782D, 16'h782D, 16'h45E1, 16'h01E1, 0, 0);
    // R5 R6 10 Mb/s half duplex
    run_chk("10half R5",   5'd2,  16'h782D, 16'h782D, 16'h0021, 16'h01E1, 0, 0);
    // R6 10 Mb/s full duplex via bit 6
    run_chk("10full R6",   5'd2,  16'h782D, 16'h782D, 16'h0041, 16'h01E1, 0, 0);
    // R4 advertisement masks partner's 100 abilities
    run_chk("mask R4",     5'd9,  16'h782D, 16'h782D, 16'h01E1, 16'h0021, 0, 0);
    // R6 duplex lock forces full
    run_chk("lock R6",     5'd9,  16'h782D, 16'h782D, 16'h01E1, 16'h0021, 1, 0);
    // R6 bit 6 with bit 7 set gives half; R5 fast
    run_chk("100half R6",  5'd31, 16'h782D, 16'h782D, 16'h00C1, 16'h01E1, 0, 0);
    // R8 start during a running check
    run_chk("busy R8",     5'd31, 16'h782D, 16'h782D, 16'h00C1, 16'h01E1, 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule